// File: doc/BRIEF.md
# Interrupt Delivery Controller with Message Writes

This block gathers service requests from four storage ports and passes them to a host in one of two ways. With message delivery off, it drives an active-low level interrupt pin. The pin stays low while any port request is high. With message delivery on, the pin stays quiet. Each new port request becomes one memory write on a valid/ready request channel, and that write carries a 64-bit address, a 16-bit data word and a dual-address-cycle flag.

Software sets the block up through a small register port. It writes the message address (low and high words) and a base data word. It then writes the control register with an allocation code and the enable bit. The block can own up to four vectors. Software may grant four, two or one of them, and the block folds the four ports onto whichever vectors were granted. The vector number is placed in the low bits of the data word. Rising requests that arrive while the channel is stalled are kept as pending vectors. They go out later in ascending vector order.

Top module: `irq_deliver`

## Requirements
- R1: After reset, message delivery is off, the pin is high, `msg_valid` is 0, and the low address, high address and data registers all read 0.
- R2: Register address 0 is the control register. It reads as {24'b0, cap64=1 at bit 7, grant[2:0] at bits 6:4, ask=3'b010 at bits 3:1, enable at bit 0}, so it reads 0x84 at reset. Writes change only bit 0 and bits 6:4.
- R3: Register address 1 holds the low message address, and its bits [1:0] always read 0. Address 2 holds the high address (32 bits), and address 3 holds the base data (bits 15:0).
- R4: While enable is 1, `irq_n` stays high whatever the port inputs do.
- R5: While enable is 0, `irq_n` is low exactly when at least one bit of `src_pend` is 1.
- R6: With enable at 1, each 0-to-1 change of a port bit results in one write. A bit that stays high produces no further writes. Rising bits seen while enable is 0 produce no write.
- R7: `msg_addr` is {high, low}. `msg_dac` is 1 exactly when the high address is non-zero.
- R8: The grant code is decoded as follows: 0 gives one vector (all ports use vector 0, and data equals base); 1 gives two vectors (ports 0 and 1 use vector 0, ports 2 and 3 use vector 1, and data[0] carries the vector); 2 or any larger code gives four vectors (port n uses vector n, and data[1:0] carries the vector).
- R9: While `msg_valid` is high and `msg_ready` is low, the request and its address, data and flag hold steady. Distinct vectors that become pending during the stall are issued in ascending vector order. Rises that map to the same pending vector merge into one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_pend | input | 4 | Per-port service request levels |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq_n | output | 1 | Active-low level interrupt pin |
| msg_valid | output | 1 | Message write request valid |
| msg_ready | input | 1 | Message write request accepted |
| msg_addr | output | 64 | Message target address |
| msg_data | output | 16 | Message data with vector in low bits |
| msg_dac | output | 1 | Use dual address cycle |

## Verification
The bench stalls the channel and then raises a port whose vector number is above those raised later. A design that issued writes in arrival order, or re-sorted the request it was already presenting, would send the vectors in the wrong order. Under two-vector allocation it raises two ports that share a vector while that vector is pending, and a design that did not merge them would send an extra write. It also holds sources high to catch level-driven repeat writes, and uses the grant code 7 to catch a design that does not fold oversized codes to four vectors. Random phases with random ready back-pressure check every issued vector against a bench-side pending set. In the wired phases they compare the pin against the OR of the inputs.

// File: rtl/irq_deliver.sv
module irq_deliver #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        src_pend,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_n,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [63:0]       msg_addr,
  output logic [DATA_W-1:0] msg_data,
  output logic              msg_dac
);

  localparam logic [2:0] ASK_CODE = 3'b010;

  logic              msi_en;
  logic [2:0]        grant;
  logic [29:0]       addr_lo;
  logic [31:0]       addr_hi;
  logic [DATA_W-1:0] data_base;
  logic [3:0]        src_q, vpend, setv, clrv;
  logic [1:0]        alloc, low_vec;
  logic              load;

  assign alloc = (grant == 3'd0) ? 2'd0 : (grant == 3'd1) ? 2'd1 : 2'd2;

  function automatic logic [1:0] vec_of(input logic [1:0] a, input int p);
    logic [1:0] pv;
    pv = 2'(p);
    case (a)
      2'd2:    return pv;
      2'd1:    return {1'b0, pv[1]};
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] data_of(input logic [1:0] a, input logic [1:0] v,
                                                input logic [DATA_W-1:0] b);
    case (a)
      2'd2:    return {b[DATA_W-1:2], v};
      2'd1:    return {b[DATA_W-1:1], v[0]};
      default: return b;
    endcase
  endfunction

  always_comb begin
    setv = '0;
    for (int p = 0; p < 4; p++)
      if (src_pend[p] && !src_q[p]) setv[vec_of(alloc, p)] = 1'b1;
  end

  always_comb begin
    low_vec = 2'd0;
    for (int v = 3; v >= 0; v--)
      if (vpend[v]) low_vec = 2'(v);
  end

  assign load = msi_en && !msg_valid && (|vpend);
  assign clrv = load ? (4'b0001 << low_vec) : 4'b0000;

  assign irq_n = !(!msi_en && (|src_pend));

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {24'h0, 1'b1, grant, ASK_CODE, msi_en};
      2'd1:    reg_rdata = {addr_lo, 2'b00};
      2'd2:    reg_rdata = addr_hi;
      default: reg_rdata = 32'(data_base);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msi_en    <= 1'b0;
      grant     <= '0;
      addr_lo   <= '0;
      addr_hi   <= '0;
      data_base <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        2'd0: begin
          msi_en <= reg_wdata[0];
          grant  <= reg_wdata[6:4];
        end
        2'd1:    addr_lo   <= reg_wdata[31:2];
        2'd2:    addr_hi   <= reg_wdata;
        default: data_base <= reg_wdata[DATA_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q     <= '0;
      vpend     <= '0;
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
      msg_dac   <= 1'b0;
    end else begin
      src_q <= src_pend;
      vpend <= msi_en ? ((vpend & ~clrv) | setv) : '0;
      if (msg_valid && msg_ready) begin
        msg_valid <= 1'b0;
      end else if (load) begin
        msg_valid <= 1'b1;
        msg_addr  <= {addr_hi, addr_lo, 2'b00};
        msg_data  <= data_of(alloc, low_vec, data_base);
        msg_dac   <= |addr_hi;
      end
    end
  end

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data) && $stable(msg_dac));

  p_dac_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_dac == (msg_addr[63:32] != 32'h0)));

  p_addr_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_addr[1:0] == 2'b00));

  p_pin_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    msi_en |-> irq_n);

  p_one_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready |=> !msg_valid);

endmodule

// File: tb/irq_deliver_test.sv
module irq_deliver_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src_pend = '0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_n, msg_valid, msg_dac;
  logic        msg_ready = 1'b0;
  logic [63:0] msg_addr;
  logic [15:0] msg_data;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  irq_deliver uut (
    .clk(clk), .rst_n(rst_n), .src_pend(src_pend), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data), .msg_dac(msg_dac)
  );

  function automatic int nvec(input int g);
    return (g == 0) ? 1 : (g == 1) ? 2 : 4;
  endfunction

  function automatic int vec_of(input int g, input int p);
    return (nvec(g) == 4) ? p : (nvec(g) == 2) ? p / 2 : 0;
  endfunction

  function automatic logic [15:0] exp_data(input logic [15:0] b, input int g, input int v);
    if (nvec(g) == 4) return {b[15:2], 2'(v)};
    if (nvec(g) == 2) return {b[15:1], 1'(v)};
    return b;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_msg(input logic [15:0] d, input logic [63:0] a, input bit dac, input string req);
    bit seen = 0;
    for (int i = 0; i < 8 && !seen; i++) begin
      @(negedge clk);
      if (msg_valid) begin
        seen = 1;
        chk(msg_data == d, req, msg_data, d);
        chk(msg_addr == a && msg_dac == dac, req, {msg_addr[62:0], msg_dac}, {a[62:0], dac});
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
      end
    end
    if (!seen) chk(1'b0, req, 0, 1);
  endtask

  task automatic expect_none(input int n, input string req);
    bit any = 0;
    msg_ready = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (msg_valid) any = 1;
    end
    msg_ready = 1'b0;
    chk(!any, req, any, 0);
  endtask

  bit [3:0]    mpend;
  logic [3:0]  cur_src, prev_src;
  bit          prev_valid;

  task automatic step(input int g, input bit en, input logic [15:0] base, input logic [3:0] ns, input bit nr);
    logic [3:0] rise;
    if (msg_valid && !prev_valid) begin
      int v = (nvec(g) == 4) ? int'(msg_data[1:0]) : (nvec(g) == 2) ? int'(msg_data[0]) : 0;
      chk(msg_data == exp_data(base, g, v), "R8 data", msg_data, exp_data(base, g, v));
      chk(mpend[v], "R6 R9 issued vector was pending", v, mpend);
      mpend[v] = 1'b0;
    end
    prev_valid = msg_valid;
    rise = cur_src & ~prev_src;
    if (en)
      for (int p = 0; p < 4; p++) if (rise[p]) mpend[vec_of(g, p)] = 1'b1;
    if (en) chk(irq_n == 1'b1, "R4 pin quiet", irq_n, 1);
    else    chk(irq_n == !(|cur_src), "R5 pin level", irq_n, !(|cur_src));
    prev_src = cur_src;
    cur_src = ns;
    src_pend = ns;
    msg_ready = nr;
    @(negedge clk);
  endtask

  task automatic random_seg(input int g, input bit en, input logic [15:0] base);
    logic [3:0] s = '0;
    wr_reg(2'd3, 32'(base));
    wr_reg(2'd0, {25'h0, 3'(g), 3'b000, en});
    mpend = '0; cur_src = '0; prev_src = '0; prev_valid = msg_valid;
    for (int i = 0; i < 400; i++) begin
      if ($urandom % 3 == 0) s = 4'($urandom);
      step(g, en, base, s, 1'($urandom));
    end
    for (int i = 0; i < 20; i++) step(g, en, base, s, 1'b1);
    for (int i = 0; i < 4; i++) step(g, en, base, 4'h0, 1'b1);
    chk(mpend == 0 && !msg_valid, "R6 R9 all pending vectors drained", mpend, 0);
  endtask

  initial begin
    #4ms;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    // R1 / R2 / R3 register view
    chk(irq_n == 1'b1 && msg_valid == 1'b0, "R1 reset outputs", {irq_n, msg_valid}, 2'b10);
    rd_chk(2'd0, 32'h84, "R1 R2 control reset");
    rd_chk(2'd1, 32'h0, "R1 low addr reset");
    rd_chk(2'd2, 32'h0, "R1 high addr reset");
    rd_chk(2'd3, 32'h0, "R1 data reset");
    wr_reg(2'd0, 32'hFFFF_FF8E);
    rd_chk(2'd0, 32'h84, "R2 read-only fields");
    wr_reg(2'd0, 32'h0);
    wr_reg(2'd1, 32'h1234_5677);
    rd_chk(2'd1, 32'h1234_5674, "R3 low addr bits forced");
    wr_reg(2'd3, 32'h0000_A5F0);
    rd_chk(2'd3, 32'h0000_A5F0, "R3 data readback");

    // R5 wired pin
    @(negedge clk); src_pend = 4'b0010; #1;
    chk(irq_n == 1'b0, "R5 pin low while pending", irq_n, 0);
    @(negedge clk); src_pend = 4'b0000; #1;
    chk(irq_n == 1'b1, "R5 pin released", irq_n, 1);
    expect_none(4, "R6 no write while disabled");

    // R9 ordering, four vectors, 32-bit address
    wr_reg(2'd0, 32'h21);
    @(negedge clk); src_pend = 4'b1000; #1;
    chk(irq_n == 1'b1, "R4 pin quiet with MSI on", irq_n, 1);
    wait_cyc(3);
    chk(msg_valid == 1'b1 && msg_data == 16'hA5F3, "R9 first stalled request", msg_data, 16'hA5F3);
    src_pend = 4'b1111;
    wait_cyc(3);
    chk(msg_data == 16'hA5F3, "R9 stalled request unchanged", msg_data, 16'hA5F3);
    expect_msg(16'hA5F3, 64'h1234_5674, 1'b0, "R9 R7 order vec3");
    expect_msg(16'hA5F0, 64'h1234_5674, 1'b0, "R9 order vec0");
    expect_msg(16'hA5F1, 64'h1234_5674, 1'b0, "R9 order vec1");
    expect_msg(16'hA5F2, 64'h1234_5674, 1'b0, "R9 order vec2");
    expect_none(6, "R6 held sources no repeat");
    src_pend = 4'b0000;

    // R9 merge, two vectors, 64-bit address
    wr_reg(2'd2, 32'h0000_0001);
    wr_reg(2'd0, 32'h11);
    @(negedge clk); src_pend = 4'b0100;
    wait_cyc(3);
    src_pend = 4'b0111;
    wait_cyc(3);
    expect_msg(16'hA5F1, 64'h1_1234_5674, 1'b1, "R8 R7 two-vector port2");
    expect_msg(16'hA5F0, 64'h1_1234_5674, 1'b1, "R9 merged ports 0 and 1");
    expect_none(6, "R9 merge leaves no extra write");
    src_pend = 4'b0000;
    wr_reg(2'd2, 32'h0);

    // R8 one vector and oversized code
    wr_reg(2'd0, 32'h01);
    @(negedge clk); src_pend = 4'b1000;
    expect_msg(16'hA5F0, 64'h1234_5674, 1'b0, "R8 one vector");
    src_pend = 4'b1000;
    expect_none(5, "R6 level held");
    src_pend = 4'b0000;
    wr_reg(2'd0, 32'h71);
    @(negedge clk); src_pend = 4'b1000;
    expect_msg(16'hA5F3, 64'h1234_5674, 1'b0, "R8 code 7 acts as four");
    src_pend = 4'b0000;

    // R6 disable suppresses writes
    wr_reg(2'd0, 32'h0);
    @(negedge clk); src_pend = 4'b0001; #1;
    chk(irq_n == 1'b0, "R5 pin returns when disabled", irq_n, 0);
    expect_none(5, "R6 disabled rise ignored");
    src_pend = 4'b0000;

    // random phases
    random_seg(0, 1'b1, 16'h3C30);
    random_seg(1, 1'b1, 16'h9E11);
    random_seg(2, 1'b1, 16'h4442);
    random_seg(5, 1'b1, 16'h0007);
    random_seg(2, 1'b0, 16'h1111);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule